// File: doc/BRIEF.md
# Serial Channel Interrupt Source and Trigger Controller

This block turns the state of one serial channel into a single level interrupt request and a receive-DMA busy indication. It keeps a four-bit source register, in which each bit latches one cause: receive, error, transmit and modem. It also keeps a four-bit mask register. The pending vector is the source register with the masked bits removed. A registered interrupt line follows the OR of the pending vector.

The receive and transmit FIFOs are outside the block, and so is the receive timeout counter. The block sees only their fill counts, the data-ready flag and event pulses. It compares each fill count with a programmable trigger level. The size of one trigger step depends on a channel-number parameter, because channels of different FIFO depth share this logic.

Software clears causes by writing ones through either of two clear strobes and programs the mask through a write strobe. The FIFO control fields (enable, trigger selects, timeout enable, receive mode) come in as plain inputs from the channel's control registers.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Source bit positions are fixed. Bit 0 is receive, bit 1 is error, bit 2 is transmit and bit 3 is modem.
- R2: `pend` equals `src & ~mask`. `irq` is a register that shows, one clock later, whether `pend` was nonzero.
- R3: With `clr_pend` or `clr_src` high, each source bit whose `wr_data` bit is 1 is cleared at the next edge. Source bits whose `wr_data` bit is 0 keep their value.
- R4: With `mask_we` high, the mask register takes `wr_data` at the next edge. A masked cause stays latched in `src` and is dropped from `pend`.
- R5: One trigger step is 32 entries on channel 0, 8 on channels 1 and 4, and 2 on channels 2 and 3. Every other channel number gives a trigger level of 0.
- R6: With `fifo_en` high, the transmit bit (bit 2) is set when `tx_count` is at or below `tx_trig_sel` times the step.
- R7: With `fifo_en` high, the receive bit (bit 0) is set when `rx_count` is at or above (`rx_trig_sel` + 1) times the step.
- R8: With `fifo_en` high and `rx_tout_en` low, any nonzero `rx_count` sets the receive bit.
- R9: With `fifo_en` low, the receive bit is set whenever `rx_ready` is high, and the FIFO count comparisons set nothing.
- R10: `err_evt` sets bit 1, `modem_evt` sets bit 3, `rx_tout_evt` sets bit 0 and `tx_done_evt` sets bit 2, each at the next edge.
- R11: When a set condition and a clear of the same bit occur in the same cycle, the bit ends up set.
- R12: One clock after `rx_mode` equals 2'b10 (receive DMA mode) while `rx_count` is 0, `dma_busy` is high. Otherwise it is low one clock later.
- R13: Synchronous reset clears the source and mask registers, `irq` and `dma_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable |
| rx_tout_en | input | 1 | Receive timeout enable |
| rx_mode | input | 2 | Receive transfer mode; 2'b10 selects DMA |
| tx_trig_sel | input | 3 | Transmit trigger step count |
| rx_trig_sel | input | 3 | Receive trigger step count minus one |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_ready | input | 1 | Receive data-ready flag (non-FIFO mode) |
| err_evt | input | 1 | Error event pulse |
| modem_evt | input | 1 | Modem status event pulse |
| rx_tout_evt | input | 1 | Receive timeout expiry pulse |
| tx_done_evt | input | 1 | Transmit completion pulse |
| wr_data | input | 4 | Write data for clear and mask strobes |
| clr_pend | input | 1 | Write-one-to-clear through the pending view |
| clr_src | input | 1 | Write-one-to-clear on the source register |
| mask_we | input | 1 | Mask register write strobe |
| src | output | 4 | Source register |
| pend | output | 4 | Pending vector (source with masked bits removed) |
| irq | output | 1 | Registered level interrupt request |
| dma_busy | output | 1 | Registered receive-DMA busy flag |

## Verification
The trigger comparisons are run against three channel scales at the same time, including a channel with no defined scale. Each comparison is tried just below, at and just above its level. A design that drops the +1 on the receive select, or uses a strict comparison in place of an inclusive one, flips a bit at exactly those counts.

Clears are applied to some bits and not others, to show that a one in `wr_data` clears and a zero preserves. Clears are also applied while a level condition is still true, which exposes a clear that overrides a set.

The bench checks the `irq` timing cycle by cycle. A combinational interrupt line, or one that ignores the mask, would show up one cycle early or not fall at all.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned NSRC = 4;

  typedef enum logic [1:0] {
    SRC_RX    = 2'd0,
    SRC_ERR   = 2'd1,
    SRC_TX    = 2'd2,
    SRC_MODEM = 2'd3
  } src_idx_e;

  localparam logic [1:0] MODE_RX_DMA = 2'b10;

  // entries per trigger step for a given channel number
  function automatic int unsigned trig_scale(input int unsigned ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int unsigned CHANNEL = 0,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned SEL_W   = 3
) (
  input  logic [SEL_W-1:0] tx_sel,
  input  logic [SEL_W-1:0] rx_sel,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  output logic             tx_hit,
  output logic             rx_hit
);
  import uart_irq_pkg::*;

  localparam int unsigned SCALE = trig_scale(CHANNEL);
  localparam int unsigned MAXLV = ((1 << SEL_W)) * ((SCALE == 0) ? 1 : SCALE);
  localparam int unsigned LVL_W = $clog2(MAXLV + 1);
  localparam int unsigned CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

  logic [CMP_W-1:0] tx_lvl, rx_lvl;
  logic [CMP_W-1:0] tx_cnt_x, rx_cnt_x;

  assign tx_cnt_x = CMP_W'(tx_count);
  assign rx_cnt_x = CMP_W'(rx_count);

  generate
    if (SCALE == 0) begin : g_noscale
      assign tx_lvl = '0;
      assign rx_lvl = '0;
    end else begin : g_scale
      logic [CMP_W-1:0] rx_steps;
      assign rx_steps = CMP_W'(rx_sel) + CMP_W'(1);
      assign tx_lvl   = CMP_W'(tx_sel) * CMP_W'(SCALE);
      assign rx_lvl   = rx_steps * CMP_W'(SCALE);
    end
  endgenerate

  assign tx_hit = (tx_cnt_x <= tx_lvl);
  assign rx_hit = (rx_cnt_x >= rx_lvl);

endmodule

// File: rtl/uart_irq_srcreg.sv
module uart_irq_srcreg #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         clr_en,
  input  logic [N-1:0] clr_bits,
  input  logic         mask_we,
  input  logic [N-1:0] mask_din,
  output logic [N-1:0] src_q,
  output logic [N-1:0] mask_q
);
  logic [N-1:0] clr_vec;
  assign clr_vec = clr_en ? clr_bits : '0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)             src_q[i] <= 1'b0;
        else if (set_vec[i]) src_q[i] <= 1'b1;
        else if (clr_vec[i]) src_q[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_we) mask_q <= mask_din;
  end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int unsigned CHANNEL = 0,
  parameter int unsigned CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             rx_tout_en,
  input  logic [1:0]       rx_mode,
  input  logic [2:0]       tx_trig_sel,
  input  logic [2:0]       rx_trig_sel,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_ready,
  input  logic             err_evt,
  input  logic             modem_evt,
  input  logic             rx_tout_evt,
  input  logic             tx_done_evt,
  input  logic [3:0]       wr_data,
  input  logic             clr_pend,
  input  logic             clr_src,
  input  logic             mask_we,
  output logic [3:0]       src,
  output logic [3:0]       pend,
  output logic             irq,
  output logic             dma_busy
);
  import uart_irq_pkg::*;

  logic tx_hit, rx_hit;
  logic rx_any;
  logic rx_cond, tx_cond;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] src_q, mask_q;
  logic irq_q, dma_q;

  uart_irq_trig #(
    .CHANNEL (CHANNEL),
    .CNT_W   (CNT_W),
    .SEL_W   (3)
  ) u_trig (
    .tx_sel   (tx_trig_sel),
    .rx_sel   (rx_trig_sel),
    .tx_count (tx_count),
    .rx_count (rx_count),
    .tx_hit   (tx_hit),
    .rx_hit   (rx_hit)
  );

  assign rx_any  = (rx_count != '0);
  assign rx_cond = fifo_en ? ((rx_any && !rx_tout_en) || rx_hit) : rx_ready;
  assign tx_cond = fifo_en && tx_hit;

  always_comb begin
    set_vec            = '0;
    set_vec[SRC_RX]    = rx_cond || rx_tout_evt;
    set_vec[SRC_ERR]   = err_evt;
    set_vec[SRC_TX]    = tx_cond || tx_done_evt;
    set_vec[SRC_MODEM] = modem_evt;
  end

  uart_irq_srcreg #(.N(NSRC)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .clr_en   (clr_pend || clr_src),
    .clr_bits (wr_data),
    .mask_we  (mask_we),
    .mask_din (wr_data),
    .src_q    (src_q),
    .mask_q   (mask_q)
  );

  assign src  = src_q;
  assign pend = src_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      irq_q <= |pend;
      dma_q <= (rx_mode == MODE_RX_DMA) && !rx_any;
    end
  end

  assign irq      = irq_q;
  assign dma_busy = dma_q;

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       rx_mode,
  input logic [CNT_W-1:0] rx_count,
  input logic             err_evt,
  input logic             modem_evt,
  input logic [3:0]       wr_data,
  input logic             clr_pend,
  input logic             clr_src,
  input logic [3:0]       src,
  input logic [3:0]       pend,
  input logic             irq,
  input logic             dma_busy
);
  logic past_rst;
  always_ff @(posedge clk) past_rst <= rst;

  always_ff @(posedge clk) begin
    if (past_rst && !rst) begin
      AST_RESET_CLEAR: assert (src == 4'b0 && !irq && !dma_busy); // R13
    end
  end

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst || past_rst)
    irq == (|$past(pend))); // R2

  AST_PEND_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (pend & ~src) == 4'b0); // R4

  AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
    err_evt |=> src[1]); // R10

  AST_MODEM_SETS: assert property (@(posedge clk) disable iff (rst)
    modem_evt |=> src[3]); // R1

  AST_CLEAR_SELECTIVE: assert property (@(posedge clk) disable iff (rst)
    (clr_pend || clr_src) |=> (($past(src) & ~$past(wr_data) & ~src) == 4'b0)); // R3

  AST_DMA_BUSY: assert property (@(posedge clk) disable iff (rst || past_rst)
    dma_busy == $past(rx_mode == 2'b10 && rx_count == '0)); // R12

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rx_mode  (rx_mode),
  .rx_count (rx_count),
  .err_evt  (err_evt),
  .modem_evt(modem_evt),
  .wr_data  (wr_data),
  .clr_pend (clr_pend),
  .clr_src  (clr_src),
  .src      (src),
  .pend     (pend),
  .irq      (irq),
  .dma_busy (dma_busy)
);

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst;
  logic fifo_en, rx_tout_en, rx_ready;
  logic [1:0] rx_mode;
  logic [2:0] tx_trig_sel, rx_trig_sel;
  logic [CW-1:0] tx_count, rx_count;
  logic err_evt, modem_evt, rx_tout_evt, tx_done_evt;
  logic [3:0] wr_data;
  logic clr_pend, clr_src, mask_we;
  logic [3:0] src2, pend2, src1, pend1, src7, pend7;
  logic irq2, dma2, irq1, dma1, irq7, dma7;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl #(.CHANNEL(2), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_tout_en(rx_tout_en),
    .rx_mode(rx_mode), .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel),
    .tx_count(tx_count), .rx_count(rx_count), .rx_ready(rx_ready),
    .err_evt(err_evt), .modem_evt(modem_evt), .rx_tout_evt(rx_tout_evt),
    .tx_done_evt(tx_done_evt), .wr_data(wr_data), .clr_pend(clr_pend),
    .clr_src(clr_src), .mask_we(mask_we), .src(src2), .pend(pend2),
    .irq(irq2), .dma_busy(dma2));

  uart_irq_ctrl #(.CHANNEL(1), .CNT_W(CW)) uut_c1 (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_tout_en(rx_tout_en),
    .rx_mode(rx_mode), .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel),
    .tx_count(tx_count), .rx_count(rx_count), .rx_ready(rx_ready),
    .err_evt(err_evt), .modem_evt(modem_evt), .rx_tout_evt(rx_tout_evt),
    .tx_done_evt(tx_done_evt), .wr_data(wr_data), .clr_pend(clr_pend),
    .clr_src(clr_src), .mask_we(mask_we), .src(src1), .pend(pend1),
    .irq(irq1), .dma_busy(dma1));

  uart_irq_ctrl #(.CHANNEL(7), .CNT_W(CW)) uut_c7 (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_tout_en(rx_tout_en),
    .rx_mode(rx_mode), .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel),
    .tx_count(tx_count), .rx_count(rx_count), .rx_ready(rx_ready),
    .err_evt(err_evt), .modem_evt(modem_evt), .rx_tout_evt(rx_tout_evt),
    .tx_done_evt(tx_done_evt), .wr_data(wr_data), .clr_pend(clr_pend),
    .clr_src(clr_src), .mask_we(mask_we), .src(src7), .pend(pend7),
    .irq(irq7), .dma_busy(dma7));

  typedef struct packed {
    logic       fe;
    logic       toen;
    logic [2:0] txs;
    logic [2:0] rxs;
    logic [7:0] txc;
    logic [7:0] rxc;
    logic       drdy;
    logic       exp_rx;   // channel 2 expectation
    logic       exp_tx;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 3'd2, 3'd1, 8'd4,  8'd3,  1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b1, 3'd2, 3'd1, 8'd5,  8'd4,  1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b0, 3'd0, 3'd7, 8'd0,  8'd1,  1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b0, 3'd0, 3'd7, 8'd1,  8'd0,  1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 3'd7, 3'd0, 8'd0,  8'd9,  1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 3'd7, 3'd0, 8'd0,  8'd9,  1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b1, 3'd7, 3'd7, 8'd14, 8'd16, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b1, 3'd7, 3'd7, 8'd15, 8'd15, 1'b0, 1'b0, 1'b0}
  };

  function automatic int scl(input int ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [1:0] expect_rt(input vec_t v, input int ch);
    logic r, t;
    t = v.fe && (int'(v.txc) <= int'(v.txs) * scl(ch));
    if (v.fe) r = ((v.rxc != 0) && !v.toen) || (int'(v.rxc) >= (int'(v.rxs) + 1) * scl(ch));
    else      r = v.drdy;
    return {r, t};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs;
    fifo_en = 0; rx_tout_en = 1; rx_ready = 0; rx_mode = 2'b00;
    tx_trig_sel = 0; rx_trig_sel = 0; tx_count = 8'd1; rx_count = 8'd0;
    err_evt = 0; modem_evt = 0; rx_tout_evt = 0; tx_done_evt = 0;
    wr_data = 0; clr_pend = 0; clr_src = 0; mask_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    @(negedge clk); step(); step();
    rst = 0;
    // R13 reset state
    chk("R13 src", {4'b0, src2}, 8'h00);
    chk("R13 irq/dma", {6'b0, irq2, dma2}, 8'h00);

    // vector table: clear all sources while conditions are applied; set wins
    for (int i = 0; i < NVEC; i++) begin
      fifo_en = VECS[i].fe; rx_tout_en = VECS[i].toen;
      tx_trig_sel = VECS[i].txs; rx_trig_sel = VECS[i].rxs;
      tx_count = VECS[i].txc; rx_count = VECS[i].rxc; rx_ready = VECS[i].drdy;
      wr_data = 4'hF; clr_src = 1;
      step();
      clr_src = 0;
      // R6 R7 R8 R9 channel 2
      chk("R6/R7/R8/R9 ch2", {6'b0, src2[0], src2[2]}, {6'b0, VECS[i].exp_rx, VECS[i].exp_tx});
      // R5 scale 8
      chk("R5 ch1", {6'b0, src1[0], src1[2]}, {6'b0, expect_rt(VECS[i], 1)});
      // R5 undefined channel: level 0
      chk("R5 ch7", {6'b0, src7[0], src7[2]}, {6'b0, expect_rt(VECS[i], 7)});
    end

    // back to quiet, clear everything
    idle_inputs();
    wr_data = 4'hF; clr_pend = 1; step(); clr_pend = 0; step();
    chk("R3 all cleared", {4'b0, src2}, 8'h00);
    chk("R2 irq low", {7'b0, irq2}, 8'h00);

    // R10 R1 error event, R2 registered irq timing
    err_evt = 1; step(); err_evt = 0;
    chk("R1 err bit", {4'b0, src2}, 8'h02);
    chk("R2 irq one cycle late", {7'b0, irq2}, 8'h00);
    step();
    chk("R2 irq raised", {7'b0, irq2}, 8'h01);

    // R4 mask hides pending, source kept
    wr_data = 4'b0010; mask_we = 1; step(); mask_we = 0;
    chk("R4 pend masked", {4'b0, pend2}, 8'h00);
    chk("R4 src kept", {4'b0, src2}, 8'h02);
    step();
    chk("R2 irq dropped", {7'b0, irq2}, 8'h00);

    // R10 remaining events
    modem_evt = 1; rx_tout_evt = 1; tx_done_evt = 1; step();
    modem_evt = 0; rx_tout_evt = 0; tx_done_evt = 0;
    chk("R10 R1 all events", {4'b0, src2}, 8'h0F);
    chk("R4 pend with mask", {4'b0, pend2}, 8'h0D);

    // R3 selective clear through source strobe
    wr_data = 4'b1000; clr_src = 1; step(); clr_src = 0;
    chk("R3 src clear bit3 only", {4'b0, src2}, 8'h07);
    // R3 clear through pending strobe
    wr_data = 4'b0100; clr_pend = 1; step(); clr_pend = 0;
    chk("R3 pend clear bit2", {4'b0, src2}, 8'h03);
    chk("R4 mask unchanged", {4'b0, pend2}, 8'h01);

    // R11 set wins over clear (non-FIFO data ready)
    rx_ready = 1; wr_data = 4'b0001; clr_src = 1; step(); clr_src = 0;
    chk("R11 set beats clear", {4'b0, src2}, 8'h03);
    rx_ready = 0;
    // R9 count has no effect with FIFO disabled
    wr_data = 4'hF; clr_src = 1; step(); clr_src = 0;
    rx_count = 8'd20; tx_count = 8'd0; step();
    chk("R9 counts ignored", {4'b0, src2}, 8'h00);

    // R12 DMA busy
    rx_mode = 2'b10; rx_count = 8'd0; step();
    chk("R12 busy when empty", {7'b0, dma2}, 8'h01);
    rx_count = 8'd1; step();
    chk("R12 ready with data", {7'b0, dma2}, 8'h00);
    rx_mode = 2'b01; rx_count = 8'd0; step();
    chk("R12 not DMA mode", {7'b0, dma2}, 8'h00);

    // R13 reset again after activity
    err_evt = 1; step(); err_evt = 0;
    rst = 1; step(); rst = 0;
    chk("R13 reset clears", {3'b0, irq2, src2}, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule